// File: doc/BRIEF.md
# Selectable CPU Clock Divider

This block derives a processor clock from a faster source clock. A two-bit path select picks one of three fixed division ratios (1, 2, 3) or a programmable even ratio of twice an N value. The select lives in one control word and N lives in another, and both are written through a simple write port. The divider runs entirely on the source clock. It produces a clock-enable pulse once per output period and a divided clock level. For even ratios taken from the programmable path, that level has a 50% duty cycle.

Writes land in a staged copy of the two fields. The divider adopts the staged values only where one output period ends and the next begins, so a period that is under way always finishes at its old length and no runt pulse appears. The block reports the ratio now in force. It also flags the one illegal setting, the programmable path with N equal to zero. While that setting is in force the outputs are held low.

Top module: `cpudiv_top`

## Requirements
- R1: With the select field (bits 3:2 of the word at byte offset 0x40) at 0, 1 or 2, the output period is 1, 2 or 3 source cycles.
- R2: With the select field at 3, the output period is 2×N source cycles, where N is bits 28:20 of the word at byte offset 0x00.
- R3: `div_ce` is high in the first source cycle of each output period. `div_clk` is high for the first ceil(ratio/2) cycles of each period and low for the rest, which gives exactly 50% for every even ratio.
- R4: A write that changes the ratio in the middle of a period does not shorten or stretch that period. The new ratio starts with the next period.
- R5: A write that lands in the last cycle of a period governs the period that starts right after it.
- R6: With select 3 and N 0 in force, `cfg_err` is high, `div_ratio` reads 0, and `div_clk` and `div_ce` stay low. A write of a legal setting in that state takes effect in the next cycle, which starts a period with `div_ce` high.
- R7: `div_ratio` reports the ratio in force, and it changes only in a cycle that starts a new period or that enters the error state.
- R8: After reset both words are zero, so the ratio is 1, `div_ce` and `div_clk` are high in every cycle, and `cfg_err` is low.
- R9: Writes to any other offset, and bits outside the two fields, have no effect on the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control words |
| cfg_addr | input | ADDR_W (8) | Byte offset of the word to write |
| cfg_wdata | input | DATA_W (32) | Write data |
| div_ce | output | 1 | One-cycle enable at the start of each output period |
| div_clk | output | 1 | Divided clock level |
| div_ratio | output | N_W+1 (10) | Effective divide ratio, 0 when the setting is illegal |
| cfg_err | output | 1 | Illegal setting (select 3, N 0) in force |

## Verification
Two functions can fall in the same source cycle: a register write and the reload of the active ratio at a period boundary. The bench provokes this by aligning a write to the last cycle of a period. The divider must forward the written value, so the following period already has the new length and `div_ratio` shows it one cycle after the write. The bench also places writes in the middle of a long period. It judges that case by counting the source cycles between successive `div_ce` pulses, which must still match the old ratio.

// File: rtl/cpudiv_pkg.sv
package cpudiv_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      PATH_DIV1 = 2'd0,
      PATH_DIV2 = 2'd1,
      PATH_DIV3 = 2'd2,
      PATH_EVEN = 2'd3
   } path_e;

endpackage

// File: rtl/cpudiv_regs.sv
module cpudiv_regs
   import cpudiv_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int N_W      = 9,
   parameter int N_LSB    = 20,
   parameter int SEL_LSB  = 2,
   parameter int N_ADDR   = 'h00,
   parameter int SEL_ADDR = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output path_e             sel_nxt,
   output logic [N_W-1:0]    n_nxt
);

   localparam logic [ADDR_W-1:0] N_A   = ADDR_W'(N_ADDR);
   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

   path_e          sel_q;
   logic [N_W-1:0] n_q;
   logic           hit_n, hit_sel;

   assign hit_n   = we && (addr == N_A);
   assign hit_sel = we && (addr == SEL_A);

   // forwarded view: a write is visible to the core in its own cycle
   always_comb begin
      sel_nxt = hit_sel ? path_e'(wdata[SEL_LSB +: SEL_W]) : sel_q;
      n_nxt   = hit_n   ? wdata[N_LSB +: N_W]              : n_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= PATH_DIV1;
         n_q   <= '0;
      end else begin
         sel_q <= sel_nxt;
         n_q   <= n_nxt;
      end
   end

endmodule

// File: rtl/cpudiv_core.sv
module cpudiv_core
   import cpudiv_pkg::*;
#(
   parameter int N_W     = 9,
   parameter bit OUT_REG = 1'b0,
   localparam int R_W    = N_W + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  path_e          sel_nxt,
   input  logic [N_W-1:0] n_nxt,
   output logic           ce_out,
   output logic           lvl_out,
   output logic           err_out,
   output logic [R_W-1:0] ratio_out
);

   path_e          sel_a;
   logic [N_W-1:0] n_a;
   logic [R_W-1:0] cnt, ratio_a, half_a;
   logic [R_W:0]   half_sum;
   logic           err_a, last_a, ce_c, lvl_c;

   always_comb begin
      unique case (sel_a)
         PATH_DIV1: ratio_a = R_W'(1);
         PATH_DIV2: ratio_a = R_W'(2);
         PATH_DIV3: ratio_a = R_W'(3);
         default:   ratio_a = {n_a, 1'b0};
      endcase
   end

   assign err_a    = (ratio_a == '0);
   assign last_a   = err_a || (cnt == R_W'(ratio_a - R_W'(1)));
   assign half_sum = {1'b0, ratio_a} + (R_W+1)'(1);
   assign half_a   = half_sum[R_W:1];
   assign ce_c     = !err_a && (cnt == '0);
   assign lvl_c    = !err_a && (cnt < half_a);

   // reload only where a period ends, so no runt pulse can appear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_a <= PATH_DIV1;
         n_a   <= '0;
         cnt   <= '0;
      end else if (last_a) begin
         sel_a <= sel_nxt;
         n_a   <= n_nxt;
         cnt   <= '0;
      end else begin
         cnt   <= cnt + R_W'(1);
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_out    <= 1'b0;
               lvl_out   <= 1'b0;
               err_out   <= 1'b0;
               ratio_out <= R_W'(1);
            end else begin
               ce_out    <= ce_c;
               lvl_out   <= lvl_c;
               err_out   <= err_a;
               ratio_out <= ratio_a;
            end
         end
      end else begin : g_out_direct
         assign ce_out    = ce_c;
         assign lvl_out   = lvl_c;
         assign err_out   = err_a;
         assign ratio_out = ratio_a;
      end
   endgenerate

endmodule

// File: rtl/cpudiv_top.sv
module cpudiv_top
   import cpudiv_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int N_W      = 9,
   parameter int N_LSB    = 20,
   parameter int SEL_LSB  = 2,
   parameter int N_ADDR   = 'h00,
   parameter int SEL_ADDR = 'h40,
   parameter bit OUT_REG  = 1'b0,
   localparam int R_W     = N_W + 1
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              div_ce,
   output logic              div_clk,
   output logic [R_W-1:0]    div_ratio,
   output logic              cfg_err
);

   generate
      if (N_LSB + N_W > DATA_W) begin : g_bad_n
         $error("cpudiv_top: N field does not fit the data word");
      end
      if (SEL_LSB + SEL_W > DATA_W) begin : g_bad_sel
         $error("cpudiv_top: select field does not fit the data word");
      end
      if (N_ADDR == SEL_ADDR) begin : g_bad_addr
         $error("cpudiv_top: the two control words need distinct offsets");
      end
      if (N_W < 1) begin : g_bad_w
         $error("cpudiv_top: N_W must be at least 1");
      end
   endgenerate

   path_e          sel_nxt;
   logic [N_W-1:0] n_nxt;

   cpudiv_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .N_LSB(N_LSB),
      .SEL_LSB(SEL_LSB), .N_ADDR(N_ADDR), .SEL_ADDR(SEL_ADDR)
   ) u_regs (
      .clk(clk_src), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .sel_nxt(sel_nxt), .n_nxt(n_nxt)
   );

   cpudiv_core #(.N_W(N_W), .OUT_REG(OUT_REG)) u_core (
      .clk(clk_src), .rst_n(rst_n), .sel_nxt(sel_nxt), .n_nxt(n_nxt),
      .ce_out(div_ce), .lvl_out(div_clk), .err_out(cfg_err),
      .ratio_out(div_ratio)
   );

endmodule

// File: rtl/cpudiv_chk.sv
module cpudiv_chk #(
   parameter int N_W  = 9,
   localparam int R_W = N_W + 1
) (
   input logic           clk_src,
   input logic           rst_n,
   input logic           div_ce,
   input logic           div_clk,
   input logic [R_W-1:0] div_ratio,
   input logic           cfg_err
);

   logic seen;
   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // the period starts in the high phase
   p_ce_in_high_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
      div_ce |-> div_clk);

   // a falling edge of the level never coincides with a period start
   p_fall_mid_period_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
      (seen && $fell(div_clk) && !cfg_err) |-> !div_ce);

   // illegal setting silences the outputs
   p_err_silent_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
      cfg_err |-> (!div_clk && !div_ce && div_ratio == '0));

   // legal setting always reports a nonzero ratio
   p_legal_nonzero_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
      !cfg_err |-> (div_ratio != '0));

   // ratio changes only where a period starts or the error state begins
   p_ratio_at_boundary_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
      (seen && !$stable(div_ratio)) |-> (div_ce || cfg_err));

   // ratios above 3 come only from the 2xN path and are even
   p_even_ratio_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
      (div_ratio > R_W'(3)) |-> !div_ratio[0]);

endmodule

bind cpudiv_top cpudiv_chk #(.N_W(N_W)) u_chk (
   .clk_src(clk_src), .rst_n(rst_n), .div_ce(div_ce), .div_clk(div_clk),
   .div_ratio(div_ratio), .cfg_err(cfg_err)
);

// File: tb/sim_cpudiv_top.sv
module sim_cpudiv_top;

   localparam int CLK_P    = 10;
   localparam int N_OFF    = 'h00;
   localparam int SEL_OFF  = 'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        div_ce, div_clk, cfg_err;
   logic [9:0]  div_ratio;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   cpudiv_top u0 (
      .clk_src(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .div_ce(div_ce), .div_clk(div_clk),
      .div_ratio(div_ratio), .cfg_err(cfg_err)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; the write is captured at the next posedge
   task automatic wr(int a, int d);
      cfg_we    = 1'b1;
      cfg_addr  = 8'(a);
      cfg_wdata = 32'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic wait_ratio(int r);
      int g = 0;
      while (int'(div_ratio) != r && g < 5000) begin @(negedge clk); g++; end
      check(int'(div_ratio) == r, "R7 ratio read-back", int'(div_ratio), r);
      g = 0;
      while (!div_ce && g < 5000) begin @(negedge clk); g++; end
   endtask

   // called at a period start; returns at the next period start
   task automatic measure(int r, string req);
      int n = 0;
      int hi = 0;
      do begin
         if (div_clk) hi++;
         n++;
         @(negedge clk);
      end while (!div_ce && n < 3000);
      check(n == r, req, n, r);
      check(hi == (r + 1) / 2, "R3 high phase", hi, (r + 1) / 2);
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int c;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(int'(div_ratio) == 1, "R8 reset ratio", int'(div_ratio), 1);
      check(div_ce && div_clk, "R8 reset outputs", {div_ce, div_clk}, 3);
      check(!cfg_err, "R8 reset err", cfg_err, 0);
      measure(1, "R8 period");

      // R1 fixed paths
      for (int s = 0; s < 3; s++) begin
         wr(SEL_OFF, s << 2);
         wait_ratio(s + 1);
         measure(s + 1, "R1 fixed period");
      end

      // R2 programmable even path
      wr(N_OFF, 1 << 20);
      wr(SEL_OFF, 3 << 2);
      for (int n = 1; n <= 24; n++) begin
         wr(N_OFF, n << 20);
         wait_ratio(2 * n);
         measure(2 * n, "R2 even period");
      end
      wr(N_OFF, 511 << 20);
      wait_ratio(1022);
      measure(1022, "R2 max period");

      // R4 mid-period change keeps the current period
      wr(N_OFF, 20 << 20);
      wait_ratio(40);
      c = 0;
      repeat (5) begin @(negedge clk); c++; end
      wr(N_OFF, 2 << 20);
      c++;
      while (!div_ce && c < 3000) begin @(negedge clk); c++; end
      check(c == 40, "R4 old period kept", c, 40);
      check(int'(div_ratio) == 4, "R4 new ratio at boundary", int'(div_ratio), 4);
      measure(4, "R4 new period");

      // R5 write in the last cycle of a period
      repeat (3) @(negedge clk);
      wr(SEL_OFF, 1 << 2);
      check(div_ce == 1'b1, "R5 period start", div_ce, 1);
      check(int'(div_ratio) == 2, "R5 immediate ratio", int'(div_ratio), 2);
      measure(2, "R5 period");

      // R6 illegal setting
      wr(SEL_OFF, 3 << 2);
      wait_ratio(4);
      wr(N_OFF, 0);
      c = 0;
      while (!cfg_err && c < 100) begin @(negedge clk); c++; end
      check(cfg_err, "R6 err flag", cfg_err, 1);
      bad = 0;
      repeat (10) begin
         if (div_clk || div_ce || div_ratio != 0) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R6 outputs held low", bad, 0);
      wr(N_OFF, 3 << 20);
      check(int'(div_ratio) == 6, "R6 recovery ratio", int'(div_ratio), 6);
      check(div_ce && !cfg_err, "R6 recovery start", {div_ce, cfg_err}, 2);
      measure(6, "R6 recovery period");

      // R9 foreign offsets and bits
      wr('h20, 32'hFFFF_FFFF);
      wr(N_OFF, 32'hE000_0000 | (3 << 20) | 32'h000F_FFFF);
      wr(SEL_OFF, 32'hFFFF_FFF3 | (3 << 2));
      repeat (20) @(negedge clk);
      check(int'(div_ratio) == 6, "R9 ratio unchanged", int'(div_ratio), 6);
      wait_ratio(6);
      measure(6, "R9 period unchanged");

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule